// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out trap entry for a 32-bit processor core. It accepts a general exception request with a cause code, the PC of the faulting instruction and an optional faulting address. It also accepts a debug exception request with its own cause code and PC. For each request it takes, it commits every architectural side effect in a single clock edge: the status word, the saved-PC and saved-status banks, the cause register, the fault-address register and the debug-cause register. On that same edge it raises a one-cycle redirect strobe together with a vector identifier, and the fetch unit uses the pair to steer to the handler.

A general exception raised while the status word already shows exception mode goes to a separate double-exception vector. Its PC goes to a dedicated double-exception PC register when the core has one. Debug entry is allowed only below the configured debug interrupt level. Debug entry saves PC and status into the bank slot for that level and raises the interrupt level to it. The surrounding pipeline can load the status word through a write port. Individual bank slots can be read back through a level-selected read port.

Top module: `trap_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: the status word, the cause, fault-address, double-exception PC and debug-cause registers, and every bank slot. `redirect` is 0 and `vec` is 0 (no vector).
- R2: A general request taken while status bit 4 (exception mode) is 0 and bit 5 (user mode) is 0 selects vector code 1 (kernel). It saves the PC in bank slot 1 and writes the 6-bit cause. It sets status bit 4 and leaves bits 5 and 3:0 unchanged. `redirect` is 1 for exactly the cycle after the request cycle.
- R3: The same request with status bit 5 set selects vector code 2 (user). Bit 5 stays set.
- R4: A general request taken while status bit 4 is already set selects vector code 3 (double). With `HAS_DBL_PC`=1 the PC goes to `dexc_pc` and bank slot 1 is left unchanged. With `HAS_DBL_PC`=0 the PC goes to bank slot 1.
- R5: When `gen_has_addr` is 1, `gen_addr` is written to `exc_vaddr` on the entry edge. When it is 0, `exc_vaddr` keeps its value.
- R6: A debug request is taken only when `cur_ilvl` is strictly below `DBG_LEVEL`. Otherwise it produces no redirect and changes no register.
- R7: Debug entry selects vector code 4 and writes `dbg_cause_reg`. It saves the PC in bank slot `DBG_LEVEL` and the pre-entry status word in the saved-status slot `DBG_LEVEL`. It then sets status[3:0] to `DBG_LEVEL` and sets bit 4, with bit 5 kept.
- R8: When a general request and a takeable debug request arrive in the same cycle, debug is entered first. The general request is held with its payload and entered on the next cycle. It therefore sees exception mode set and goes to the double vector.
- R9: `stat_we` loads `stat_wdata` into the status word when no entry is taken in that cycle. In a cycle where an entry is taken, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_req | input | 1 | General exception request |
| gen_cause | input | CAUSE_W | General exception cause code |
| gen_pc | input | XLEN | PC of the faulting instruction |
| gen_has_addr | input | 1 | Request carries a faulting address |
| gen_addr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | CAUSE_W | Debug cause code |
| dbg_pc | input | XLEN | PC saved on debug entry |
| cur_ilvl | input | 4 | Current interrupt level, compared against DBG_LEVEL |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | 6 | Status word write data ({um, excm, ilvl[3:0]}) |
| rd_lvl | input | $clog2(LEVELS+1) | Bank slot selected for readback |
| status | output | 6 | Status word: [3:0] interrupt level, [4] exception mode, [5] user mode |
| exc_cause | output | CAUSE_W | Cause register |
| exc_vaddr | output | XLEN | Fault-address register |
| dexc_pc | output | XLEN | Double-exception PC register |
| dbg_cause_reg | output | CAUSE_W | Debug-cause register |
| rd_pc | output | XLEN | Saved PC of slot rd_lvl (0 for slot 0) |
| rd_ps | output | 6 | Saved status of slot rd_lvl (0 for slot 0) |
| vec | output | 3 | Vector code, valid with redirect (0 none, 1 kernel, 2 user, 3 double, 4 debug) |
| redirect | output | 1 | One-cycle strobe on each entry |

## Verification
The bench sweeps every combination of user mode, exception mode and address presence for general entry. It runs two configurations side by side, one with the double-exception PC register and one without. A design that ignored the exception-mode bit would send a nested fault to the kernel vector and overwrite the level-1 saved PC. A design that wrote the fault address unconditionally would corrupt `exc_vaddr`.

Every interrupt level from 0 to 15 is presented with a debug request. A comparison written as less-or-equal would take debug entry at the debug level itself. The simultaneous-request case catches a design that drops the losing general request, and one that enters it with the pre-debug status and so lands on the kernel vector. A status write issued in the same cycle as an entry catches a design that lets the write override the exception-mode bit.

// File: rtl/trap_pkg.sv
// Shared types for the trap entry sequencer.
// Assumes a 6-bit status word: [3:0] interrupt level, [4] exception mode, [5] user mode.
package trap_pkg;
    typedef enum logic [2:0] {
        VEC_NONE   = 3'd0,
        VEC_KERNEL = 3'd1,
        VEC_USER   = 3'd2,
        VEC_DOUBLE = 3'd3,
        VEC_DEBUG  = 3'd4
    } vec_e;

    localparam int ST_W = 6;

    typedef struct packed {
        logic       um;
        logic       excm;
        logic [3:0] ilvl;
    } status_t;
endpackage

// File: rtl/trap_arb.sv
// Request arbiter: decides between debug and general entry each cycle.
// A takeable debug request wins; a general request that loses is held with
// its payload and offered again next cycle, ahead of any new general request.
module trap_arb #(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int DBG_LEVEL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_req,
    input  logic [CAUSE_W-1:0] gen_cause,
    input  logic [XLEN-1:0]    gen_pc,
    input  logic               gen_has_addr,
    input  logic [XLEN-1:0]    gen_addr,
    input  logic               dbg_req,
    input  logic [3:0]         cur_ilvl,
    output logic               take_gen,
    output logic               take_dbg,
    output logic [CAUSE_W-1:0] sel_cause,
    output logic [XLEN-1:0]    sel_pc,
    output logic               sel_has_addr,
    output logic [XLEN-1:0]    sel_addr
);
    logic               pend_q;
    logic [CAUSE_W-1:0] pend_cause_q;
    logic [XLEN-1:0]    pend_pc_q;
    logic               pend_ha_q;
    logic [XLEN-1:0]    pend_addr_q;
    logic               gen_any;

    // Gate debug by level, choose the winner and the general payload source.
    always_comb begin
        take_dbg     = dbg_req && (cur_ilvl < 4'(DBG_LEVEL));
        gen_any      = pend_q || gen_req;
        take_gen     = gen_any && !take_dbg;
        sel_cause    = pend_q ? pend_cause_q : gen_cause;
        sel_pc       = pend_q ? pend_pc_q    : gen_pc;
        sel_has_addr = pend_q ? pend_ha_q    : gen_has_addr;
        sel_addr     = pend_q ? pend_addr_q  : gen_addr;
    end

    // Hold a deferred general request until it is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_cause_q <= '0;
            pend_pc_q    <= '0;
            pend_ha_q    <= 1'b0;
            pend_addr_q  <= '0;
        end else if (take_dbg && gen_any) begin
            pend_q       <= 1'b1;
            pend_cause_q <= sel_cause;
            pend_pc_q    <= sel_pc;
            pend_ha_q    <= sel_has_addr;
            pend_addr_q  <= sel_addr;
        end else if (take_gen) begin
            pend_q <= 1'b0;
        end
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_dbg && gen_req) |=> (take_gen || take_dbg));
endmodule

// File: rtl/trap_vsel.sv
// Vector selector: picks the handler vector and the PC save target from the
// arbiter decision and the current status word. Purely combinational.
module trap_vsel
    import trap_pkg::*;
#(
    parameter bit HAS_DBL_PC = 1'b1
) (
    input  logic    take_gen,
    input  logic    take_dbg,
    input  status_t st,
    output vec_e    vec,
    output logic    to_depc,
    output logic    to_epc1
);
    logic gen_only;

    // Choose the vector: debug, double, user or kernel.
    always_comb begin
        gen_only = take_gen && !take_dbg;
        vec      = VEC_NONE;
        if (take_dbg)     vec = VEC_DEBUG;
        else if (take_gen) begin
            if (st.excm)    vec = VEC_DOUBLE;
            else if (st.um) vec = VEC_USER;
            else            vec = VEC_KERNEL;
        end
    end

    generate
        if (HAS_DBL_PC) begin : g_dpc
            assign to_depc = gen_only && st.excm;
            assign to_epc1 = gen_only && !st.excm;
        end else begin : g_nodpc
            assign to_depc = 1'b0;
            assign to_epc1 = gen_only;
        end
    endgenerate
endmodule

// File: rtl/trap_bank.sv
// Level-indexed saved-PC / saved-status bank, slots 1..LEVELS.
// Slot 0 does not exist and reads as zero; a write targets one slot.
module trap_bank #(
    parameter int XLEN   = 32,
    parameter int LEVELS = 7,
    parameter int ST_W   = 6,
    parameter int IW     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_pc_en,
    input  logic            wr_ps_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_pc,
    input  logic [ST_W-1:0] wr_ps,
    input  logic [IW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_pc,
    output logic [ST_W-1:0] rd_ps
);
    logic [XLEN-1:0] pc_arr [LEVELS+1];
    logic [ST_W-1:0] ps_arr [LEVELS+1];

    assign pc_arr[0] = '0;
    assign ps_arr[0] = '0;

    generate
        for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
            logic [XLEN-1:0] pc_q;
            logic [ST_W-1:0] ps_q;
            // Capture PC and status for this level when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pc_q <= '0;
                    ps_q <= '0;
                end else begin
                    if (wr_pc_en && wr_idx == IW'(l)) pc_q <= wr_pc;
                    if (wr_ps_en && wr_idx == IW'(l)) ps_q <= wr_ps;
                end
            end
            assign pc_arr[l] = pc_q;
            assign ps_arr[l] = ps_q;
        end
    endgenerate

    // Read the selected slot; out-of-range slots read zero.
    always_comb begin
        rd_pc = '0;
        rd_ps = '0;
        if (int'(rd_idx) <= LEVELS) begin
            rd_pc = pc_arr[rd_idx];
            rd_ps = ps_arr[rd_idx];
        end
    end

    // R7
    bank_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pc_en || wr_ps_en) |-> (wr_idx != '0 && int'(wr_idx) <= LEVELS));
endmodule

// File: rtl/trap_entry_seq.sv
// Trap entry sequencer top. Commits all entry side effects and the redirect
// strobe on one clock edge. Assumes 2 <= DBG_LEVEL <= LEVELS <= 15 and that
// the return path restores status through stat_we.
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int CAUSE_W    = 6,
    parameter int LEVELS     = 7,
    parameter int DBG_LEVEL  = 3,
    parameter bit HAS_DBL_PC = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        gen_req,
    input  logic [CAUSE_W-1:0]          gen_cause,
    input  logic [XLEN-1:0]             gen_pc,
    input  logic                        gen_has_addr,
    input  logic [XLEN-1:0]             gen_addr,
    input  logic                        dbg_req,
    input  logic [CAUSE_W-1:0]          dbg_cause,
    input  logic [XLEN-1:0]             dbg_pc,
    input  logic [3:0]                  cur_ilvl,
    input  logic                        stat_we,
    input  logic [5:0]                  stat_wdata,
    input  logic [$clog2(LEVELS+1)-1:0] rd_lvl,
    output logic [5:0]                  status,
    output logic [CAUSE_W-1:0]          exc_cause,
    output logic [XLEN-1:0]             exc_vaddr,
    output logic [XLEN-1:0]             dexc_pc,
    output logic [CAUSE_W-1:0]          dbg_cause_reg,
    output logic [XLEN-1:0]             rd_pc,
    output logic [5:0]                  rd_ps,
    output logic [2:0]                  vec,
    output logic                        redirect
);
    localparam int IW = $clog2(LEVELS + 1);

    status_t            st_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [XLEN-1:0]    vaddr_q;
    logic [XLEN-1:0]    depc_q;
    logic [CAUSE_W-1:0] dcause_q;
    vec_e               vec_q;
    logic               redir_q;

    logic               take_gen, take_dbg;
    logic [CAUSE_W-1:0] sel_cause;
    logic [XLEN-1:0]    sel_pc, sel_addr;
    logic               sel_has_addr;
    vec_e               vec_n;
    logic               to_depc, to_epc1;
    logic               bk_pc_en;
    logic [IW-1:0]      bk_idx;
    logic [XLEN-1:0]    bk_pc;

    trap_arb #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .DBG_LEVEL(DBG_LEVEL)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .gen_req(gen_req), .gen_cause(gen_cause), .gen_pc(gen_pc),
        .gen_has_addr(gen_has_addr), .gen_addr(gen_addr),
        .dbg_req(dbg_req), .cur_ilvl(cur_ilvl),
        .take_gen(take_gen), .take_dbg(take_dbg),
        .sel_cause(sel_cause), .sel_pc(sel_pc),
        .sel_has_addr(sel_has_addr), .sel_addr(sel_addr)
    );

    trap_vsel #(.HAS_DBL_PC(HAS_DBL_PC)) u_vsel (
        .take_gen(take_gen), .take_dbg(take_dbg), .st(st_q),
        .vec(vec_n), .to_depc(to_depc), .to_epc1(to_epc1)
    );

    // Route the bank write: debug level slot or level-1 slot.
    always_comb begin
        bk_pc_en = take_dbg || to_epc1;
        bk_idx   = take_dbg ? IW'(DBG_LEVEL) : IW'(1);
        bk_pc    = take_dbg ? dbg_pc : sel_pc;
    end

    trap_bank #(.XLEN(XLEN), .LEVELS(LEVELS), .ST_W(ST_W), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_pc_en(bk_pc_en), .wr_ps_en(take_dbg), .wr_idx(bk_idx),
        .wr_pc(bk_pc), .wr_ps(st_q), .rd_idx(rd_lvl),
        .rd_pc(rd_pc), .rd_ps(rd_ps)
    );

    // Status word: debug entry, general entry, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (take_dbg) begin
            st_q.ilvl <= 4'(DBG_LEVEL);
            st_q.excm <= 1'b1;
        end else if (take_gen) begin
            st_q.excm <= 1'b1;
        end else if (stat_we) begin
            st_q <= status_t'(stat_wdata);
        end
    end

    // Cause, fault address, double PC and debug cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q  <= '0;
            vaddr_q  <= '0;
            depc_q   <= '0;
            dcause_q <= '0;
        end else begin
            if (take_gen)                 cause_q  <= sel_cause;
            if (take_gen && sel_has_addr) vaddr_q  <= sel_addr;
            if (to_depc)                  depc_q   <= sel_pc;
            if (take_dbg)                 dcause_q <= dbg_cause;
        end
    end

    // Redirect strobe and vector, committed with the registers above.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_q <= 1'b0;
            vec_q   <= VEC_NONE;
        end else begin
            redir_q <= take_gen || take_dbg;
            vec_q   <= vec_n;
        end
    end

    assign status        = st_q;
    assign exc_cause     = cause_q;
    assign exc_vaddr     = vaddr_q;
    assign dexc_pc       = depc_q;
    assign dbg_cause_reg = dcause_q;
    assign vec           = vec_q;
    assign redirect      = redir_q;

    // R2
    redir_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (vec_q != VEC_NONE));
    // R2
    excm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> st_q.excm);
    // R3
    user_um_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && vec_q == VEC_USER) |-> st_q.um);
    // R4
    dbl_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && vec_q == VEC_DOUBLE) |-> $past(st_q.excm));
    // R6
    dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && vec_q == VEC_DEBUG) |-> ($past(cur_ilvl) < 4'(DBG_LEVEL)));
    // R7
    dbg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && vec_q == VEC_DEBUG) |-> (st_q.ilvl == 4'(DBG_LEVEL)));
endmodule

// File: tb/sim_trap_entry_seq.sv
// Bench for trap_entry_seq: two configurations (with and without the
// double-exception PC register) driven with identical stimulus.
module sim_trap_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_req = 1'b0, gen_has_addr = 1'b0, dbg_req = 1'b0, stat_we = 1'b0;
    logic [5:0]  gen_cause = '0, dbg_cause = '0, stat_wdata = '0;
    logic [31:0] gen_pc = '0, gen_addr = '0, dbg_pc = '0;
    logic [3:0]  cur_ilvl = '0;
    logic [2:0]  rd_lvl = 3'd1;

    logic [5:0]  status0, cause0, dcause0, rdps0, status1, cause1, dcause1, rdps1;
    logic [31:0] vaddr0, depc0, rdpc0, vaddr1, depc1, rdpc1;
    logic [2:0]  vec0, vec1;
    logic        redir0, redir1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected state
    logic [5:0]  e_st, e_cause, e_dcause, e_epsL;
    logic [31:0] e_vaddr, e_depc, e_epc1, e1_epc1, e_epcL;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
        .gen_pc(gen_pc), .gen_has_addr(gen_has_addr), .gen_addr(gen_addr),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc),
        .cur_ilvl(cur_ilvl), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .rd_lvl(rd_lvl), .status(status0), .exc_cause(cause0),
        .exc_vaddr(vaddr0), .dexc_pc(depc0), .dbg_cause_reg(dcause0),
        .rd_pc(rdpc0), .rd_ps(rdps0), .vec(vec0), .redirect(redir0)
    );

    trap_entry_seq #(.HAS_DBL_PC(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
        .gen_pc(gen_pc), .gen_has_addr(gen_has_addr), .gen_addr(gen_addr),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc),
        .cur_ilvl(cur_ilvl), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .rd_lvl(rd_lvl), .status(status1), .exc_cause(cause1),
        .exc_vaddr(vaddr1), .dexc_pc(depc1), .dbg_cause_reg(dcause1),
        .rd_pc(rdpc1), .rd_ps(rdps1), .vec(vec1), .redirect(redir1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_common(input string req);
        check({req, " status"}, 32'(status0), 32'(e_st));
        check({req, " cause"},  32'(cause0),  32'(e_cause));
        check({req, " vaddr"},  vaddr0,       e_vaddr);
        check({req, " depc"},   depc0,        e_depc);
        check({req, " dcause"}, 32'(dcause0), 32'(e_dcause));
        check({req, " epc1"},   rdpc0,        e_epc1);
        check({req, " u1 epc1"}, rdpc1,       e1_epc1);
        check({req, " u1 depc"}, depc1,       32'h0);
        check({req, " u1 status"}, 32'(status1), 32'(e_st));
    endtask

    // R9: load status through the write port
    task automatic wr_status(input logic [5:0] v);
        @(negedge clk);
        stat_we = 1'b1; stat_wdata = v;
        @(negedge clk);
        stat_we = 1'b0;
        e_st = v;
        check("R9 status write", 32'(status0), 32'(v));
        check("R9 no redirect", 32'(redir0), 32'h0);
    endtask

    // R2 R3 R4 R5: one general exception
    task automatic gen(input logic [5:0] c, input logic [31:0] pc,
                       input logic ha, input logic [31:0] a, input logic also_we);
        logic [2:0] ev;
        @(negedge clk);
        gen_req = 1'b1; gen_cause = c; gen_pc = pc; gen_has_addr = ha; gen_addr = a;
        stat_we = also_we; stat_wdata = 6'h0F;
        ev = e_st[4] ? 3'd3 : (e_st[5] ? 3'd2 : 3'd1);
        if (ha) e_vaddr = a;
        if (e_st[4]) e_depc = pc; else e_epc1 = pc;
        e1_epc1 = pc;
        e_cause = c;
        e_st[4] = 1'b1;
        @(negedge clk);
        gen_req = 1'b0; stat_we = 1'b0;
        check("R2 redirect", 32'(redir0), 32'h1);
        check("R3 R4 vector", 32'(vec0), 32'(ev));
        check("R4 u1 vector", 32'(vec1), 32'(ev));
        check_common(also_we ? "R9 ignored" : "R5 general");
        @(negedge clk);
        check("R2 strobe ends", 32'(redir0), 32'h0);
        check("R1 vec none", 32'(vec0), 32'h0);
    endtask

    // R6 R7: one debug request at a given current level
    task automatic dbg(input logic [5:0] c, input logic [31:0] pc, input logic [3:0] lvl);
        bit taken;
        @(negedge clk);
        dbg_req = 1'b1; dbg_cause = c; dbg_pc = pc; cur_ilvl = lvl;
        taken = (lvl < 4'd3);
        if (taken) begin
            e_epsL = e_st; e_epcL = pc; e_dcause = c;
            e_st = {e_st[5], 1'b1, 4'd3};
        end
        @(negedge clk);
        dbg_req = 1'b0;
        check("R6 debug gate", 32'(redir0), 32'(taken));
        check("R7 vector", 32'(vec0), taken ? 32'd4 : 32'd0);
        check_common("R7 debug");
        rd_lvl = 3'd3;
        #1;
        check("R7 saved pc", rdpc0, e_epcL);
        check("R7 saved ps", 32'(rdps0), 32'(e_epsL));
        rd_lvl = 3'd1;
        @(negedge clk);
        check("R6 strobe ends", 32'(redir0), 32'h0);
    endtask

    initial begin
        e_st = '0; e_cause = '0; e_dcause = '0; e_epsL = '0;
        e_vaddr = '0; e_depc = '0; e_epc1 = '0; e1_epc1 = '0; e_epcL = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 redirect", 32'(redir0), 32'h0);
        check("R1 vec", 32'(vec0), 32'h0);
        check_common("R1 reset");
        rd_lvl = 3'd3;
        #1;
        check("R1 slot3 pc", rdpc0, 32'h0);
        check("R1 slot3 ps", 32'(rdps0), 32'h0);
        rd_lvl = 3'd1;

        // Sweep: user mode x exception mode x address presence
        for (int um = 0; um < 2; um++)
            for (int ex = 0; ex < 2; ex++)
                for (int ha = 0; ha < 2; ha++) begin
                    wr_status({1'(um), 1'(ex), 4'(um * 2 + ex)});
                    gen(6'(32 + um * 8 + ex * 4 + ha * 2 + 1),
                        32'h1000_0000 + 32'(um * 256 + ex * 16 + ha),
                        1'(ha), 32'hA000_0000 + 32'(um * 4096 + ex * 64 + ha * 4), 1'b0);
                end

        // Debug gating across every current level
        for (int l = 0; l < 16; l++) begin
            wr_status({1'(l % 2), 1'b0, 4'(l % 3)});
            dbg(6'(l + 17), 32'h2000_0000 + 32'(l * 8), 4'(l));
        end

        // R8: simultaneous requests
        wr_status(6'h00);
        @(negedge clk);
        gen_req = 1'b1; gen_cause = 6'h3A; gen_pc = 32'h3000_0040;
        gen_has_addr = 1'b1; gen_addr = 32'hB000_0010;
        dbg_req = 1'b1; dbg_cause = 6'h05; dbg_pc = 32'h3000_0080; cur_ilvl = 4'd0;
        @(negedge clk);
        gen_req = 1'b0; dbg_req = 1'b0;
        e_epsL = 6'h00; e_epcL = 32'h3000_0080; e_dcause = 6'h05; e_st = 6'h13;
        check("R8 debug first", 32'(vec0), 32'd4);
        check("R8 status", 32'(status0), 32'(e_st));
        check("R8 cause untouched", 32'(cause0), 32'(e_cause));
        @(negedge clk);
        e_cause = 6'h3A; e_vaddr = 32'hB000_0010; e_depc = 32'h3000_0040;
        e1_epc1 = 32'h3000_0040;
        check("R8 held general", 32'(redir0), 32'h1);
        check("R8 double vector", 32'(vec0), 32'd3);
        check_common("R8 held");
        @(negedge clk);
        check("R8 done", 32'(redir0), 32'h0);

        // R9: status write in an entry cycle is ignored
        wr_status(6'h21);
        gen(6'h11, 32'h4000_0000, 1'b0, 32'hDEAD_0000, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule